// File: doc/BRIEF.md
# Haptic Timer Tick Source with External Clock Watchdog

This block produces the strobe that paces a haptic timer. It picks one of two sources: a tick from an internal 1 ms time base or rising edges of an external oscillator pin. It then divides the chosen source by a power of two set in a small configuration field. Every output strobe lasts one cycle and belongs to the system clock domain.

When the external pin is the chosen source and a haptic sequence is running, a watchdog measures the gap between rising edges on that pin. If the gap reaches the limit, which is 8 ms by default, the block sends a single-cycle abort toward the haptic sequencer so that a stalled oscillator cannot leave the motor driven. The timeout is counted in system clock cycles and is set by parameters for the clock rate and the limit in milliseconds.

Top module: `tick_src_sel`

## Requirements
- R1: During reset and in the first cycles after it, `tick_o` and `abort_o` are 0.
- R2: When cfg bit 0 is 0, the source is `int_tick_i`. With divide code 0 (cfg bits 3:1 = 0), each cycle in which `int_tick_i` is high gives one `tick_o` pulse in the following cycle.
- R3: Divide code n (cfg bits 3:1, n = 0 to 7) gives one `tick_o` pulse for every 2^n source strobes, so code 7 divides by 128. The pulse comes on the 2^n-th strobe.
- R4: When cfg bit 0 is 1, the source is the rising edges of `ext_osc_i`, taken through a two-flop synchronizer, and `int_tick_i` has no effect on `tick_o`.
- R5: When cfg bit 0 is 0, activity on `ext_osc_i` has no effect on `tick_o`.
- R6: `tick_o` is a single-cycle pulse for isolated source strobes.
- R7: Any change of `cfg_i` clears the divider's count. A full 2^n new strobes are then needed for the next pulse.
- R8: While cfg bit 0 is 1 and `haptic_act_i` is 1, going TIMEOUT = CLK_KHZ*WDOG_MS cycles without a synchronized rising edge gives exactly one single-cycle `abort_o` pulse.
- R9: The watchdog does nothing while cfg bit 0 is 0 or `haptic_act_i` is 0. Its window restarts when it is armed again.
- R10: Each synchronized rising edge restarts the watchdog window. Edges spaced closer than TIMEOUT never cause an abort.
- R11: After an abort, no further abort occurs until a new rising edge or a re-arm restarts the window.
- R12: Any change of `cfg_i` restarts the watchdog window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_tick_i | input | 1 | Internal 1 ms time-base strobe, system clock domain |
| ext_osc_i | input | 1 | Raw external oscillator pin, asynchronous |
| haptic_act_i | input | 1 | High while a haptic sequence runs |
| cfg_i | input | 4 | Bit 0: external source select; bits 3:1: divide code n (ratio 2^n) |
| tick_o | output | 1 | Divided tick strobe |
| abort_o | output | 1 | Watchdog abort pulse |

## Verification
The assertions check on every cycle that the synchronized edge and the abort last one cycle, that an abort only follows an armed cycle with no edge, that an edge or a configuration change clears both counters, and that no tick appears without a source strobe. Only the bench's scenarios can show the actual division ratios up to 128, that the unselected source is ignored, the exact timeout length, and that a second abort is held off until the window restarts.

// File: rtl/tick_sel_pkg.sv
package tick_sel_pkg;
   localparam int unsigned DIV_CODE_W = 3;
   localparam int unsigned DIV_CNT_W  = (1 << DIV_CODE_W) - 1;

   typedef struct packed {
      logic [DIV_CODE_W-1:0] div_code;
      logic                  ext_sel;
   } tick_cfg_t;

   localparam int unsigned CFG_W = $bits(tick_cfg_t);

   function automatic logic [DIV_CNT_W-1:0] div_mask(input logic [DIV_CODE_W-1:0] code);
      logic [DIV_CNT_W-1:0] one;
      one = {{(DIV_CNT_W-1){1'b0}}, 1'b1};
      return (one << code) - one;
   endfunction
endpackage

// File: rtl/tick_edge_sync.sv
module tick_edge_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tick_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;
   logic              rise_c;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise_c = sync_q[STAGES-1] & ~last_q;

   generate
      if (REG_OUT) begin : g_reg_out
         logic rise_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) rise_q <= 1'b0;
            else         rise_q <= rise_c;
         end
         assign rise_o = rise_q;
      end else begin : g_comb_out
         assign rise_o = rise_c;
      end
   endgenerate

   // R4: a synchronized edge is a one-cycle event
   p_rise_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);
endmodule

// File: rtl/tick_pow2_div.sv
module tick_pow2_div
   import tick_sel_pkg::*;
(
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  clr_i,
   input  logic                  stb_i,
   input  logic [DIV_CODE_W-1:0] code_i,
   output logic                  stb_o
);
   logic [DIV_CNT_W-1:0] cnt_q;
   logic [DIV_CNT_W-1:0] mask;
   logic                 wrap;

   assign mask = div_mask(code_i);
   assign wrap = (cnt_q == mask);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         stb_o <= 1'b0;
      end else begin
         stb_o <= 1'b0;
         if (clr_i) begin
            cnt_q <= '0;
         end else if (stb_i) begin
            if (wrap) begin
               cnt_q <= '0;
               stb_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R3: every output strobe follows an input strobe
   p_out_needs_in_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_o |-> $past(stb_i));
   // R7: a clear empties the count
   p_clear_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/tick_ext_wdog.sv
module tick_ext_wdog #(
   parameter int unsigned CLK_KHZ = 250000,
   parameter int unsigned WDOG_MS = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   input  logic rise_i,
   input  logic clr_i,
   output logic abort_o
);
   localparam int unsigned LIMIT = CLK_KHZ * WDOG_MS;
   localparam int unsigned CW    = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 4) begin : g_bad_limit
         $error("tick_ext_wdog: timeout must be at least 4 cycles");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          fired_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
         abort_o <= 1'b0;
      end else begin
         abort_o <= 1'b0;
         if (!arm_i || rise_i || clr_i) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
         end else if (!fired_q) begin
            if (cnt_q == CW'(LIMIT - 1)) begin
               abort_o <= 1'b1;
               fired_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R11: abort is a single pulse
   p_abort_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o |=> !abort_o);
   // R9: abort only when armed in the previous cycle
   p_abort_needs_arm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o |-> $past(arm_i));
   // R8: abort never directly follows a seen edge
   p_abort_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o |-> $past(!rise_i));
   // R10: an edge restarts the window
   p_edge_restarts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_i |=> (cnt_q == '0 && !fired_q));
   // R12: a configuration change restarts the window
   p_cfg_restarts_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/tick_src_sel.sv
module tick_src_sel
   import tick_sel_pkg::*;
#(
   parameter int unsigned CLK_KHZ     = 250000,
   parameter int unsigned WDOG_MS     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EDGE_REG    = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             int_tick_i,
   input  logic             ext_osc_i,
   input  logic             haptic_act_i,
   input  logic [CFG_W-1:0] cfg_i,
   output logic             tick_o,
   output logic             abort_o
);
   tick_cfg_t        cfg;
   logic [CFG_W-1:0] cfg_q;
   logic             cfg_chg;
   logic             ext_rise;
   logic             src_stb;
   logic             wd_arm;

   assign cfg = tick_cfg_t'(cfg_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q <= '0;
      else         cfg_q <= cfg_i;
   end

   assign cfg_chg = (cfg_i != cfg_q);
   assign src_stb = cfg.ext_sel ? ext_rise : int_tick_i;
   assign wd_arm  = cfg.ext_sel & haptic_act_i;

   tick_edge_sync #(
      .STAGES (SYNC_STAGES),
      .REG_OUT(EDGE_REG)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(ext_osc_i),
      .rise_o (ext_rise)
   );

   tick_pow2_div u_div (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (cfg_chg),
      .stb_i (src_stb),
      .code_i(cfg.div_code),
      .stb_o (tick_o)
   );

   tick_ext_wdog #(
      .CLK_KHZ(CLK_KHZ),
      .WDOG_MS(WDOG_MS)
   ) u_wdog (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .arm_i  (wd_arm),
      .rise_i (ext_rise),
      .clr_i  (cfg_chg),
      .abort_o(abort_o)
   );

   // R5: internal source selected and idle, config steady -> no tick
   p_no_tick_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg.ext_sel && !int_tick_i && cfg_i == cfg_q) |=> !tick_o);
endmodule

// File: tb/tick_src_sel_tb.sv
module tick_src_sel_tb_top;
   localparam int unsigned CLK_KHZ = 8;
   localparam int unsigned WDOG_MS = 8;
   localparam int unsigned TMO     = CLK_KHZ * WDOG_MS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       int_tick = 1'b0;
   logic       ext_osc = 1'b0;
   logic       hap_act = 1'b0;
   logic [3:0] cfg = 4'h0;
   logic       tick;
   logic       abort;

   int checks = 0;
   int fails  = 0;
   int tick_cnt = 0;
   int abort_cnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tick_src_sel #(.CLK_KHZ(CLK_KHZ), .WDOG_MS(WDOG_MS)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .int_tick_i(int_tick), .ext_osc_i(ext_osc),
      .haptic_act_i(hap_act), .cfg_i(cfg), .tick_o(tick), .abort_o(abort));

   always @(posedge clk) begin
      if (rst_n && tick)  tick_cnt  <= tick_cnt + 1;
      if (rst_n && abort) abort_cnt <= abort_cnt + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic int_pulse(input int gap);
      int_tick = 1'b1; cyc(1); int_tick = 1'b0; cyc(gap);
   endtask

   task automatic ext_pulse(input int hi, input int lo);
      ext_osc = 1'b1; cyc(hi); ext_osc = 1'b0; cyc(lo);
   endtask

   task automatic set_cfg(input logic [3:0] v);
      cfg = v; cyc(3); tick_cnt = 0; abort_cnt = 0;
   endtask

   task automatic t_reset();
      cyc(3);
      check("R1 tick in reset", int'(tick), 0);
      check("R1 abort in reset", int'(abort), 0);
      rst_n = 1'b1; cyc(3);
      check("R1 tick after reset", int'(tick), 0);
      check("R1 abort after reset", int'(abort), 0);
   endtask

   task automatic t_int_latency();
      set_cfg(4'b0000);
      int_tick = 1'b1; cyc(1); int_tick = 1'b0;
      check("R2 tick one cycle after strobe", int'(tick), 1);
      cyc(1);
      check("R6 tick lasts one cycle", int'(tick), 0);
      cyc(2); tick_cnt = 0;
      for (int i = 0; i < 9; i++) int_pulse(2);
      cyc(3);
      check("R2 divide-by-1 count", tick_cnt, 9);
   endtask

   task automatic t_div(input int code, input int pulses);
      set_cfg({code[2:0], 1'b0});
      for (int i = 0; i < pulses; i++) int_pulse(1);
      cyc(3);
      check($sformatf("R3 code %0d count", code), tick_cnt, pulses >> code);
   endtask

   task automatic t_clear_div();
      set_cfg(4'b0100);               // code 2
      for (int i = 0; i < 3; i++) int_pulse(1);
      set_cfg(4'b0110);               // code 3, count cleared
      for (int i = 0; i < 7; i++) int_pulse(1);
      cyc(3);
      check("R7 no tick before 8 new strobes", tick_cnt, 0);
      int_pulse(1); cyc(3);
      check("R7 tick on 8th new strobe", tick_cnt, 1);
   endtask

   task automatic t_ext_src();
      set_cfg(4'b0011);               // external, code 1
      for (int i = 0; i < 10; i++) begin
         ext_osc = 1'b1; cyc(4); ext_osc = 1'b0; cyc(2);
         int_pulse(3);
      end
      cyc(5);
      check("R4 external edges divided by 2", tick_cnt, 5);
      tick_cnt = 0;
      for (int i = 0; i < 6; i++) int_pulse(2);
      cyc(3);
      check("R4 internal ignored when external", tick_cnt, 0);
   endtask

   task automatic t_ext_ignored();
      set_cfg(4'b0000);
      for (int i = 0; i < 8; i++) ext_pulse(3, 3);
      cyc(5);
      check("R5 pin ignored when internal", tick_cnt, 0);
   endtask

   task automatic t_wdog_fire();
      set_cfg(4'b0001);
      ext_osc = 1'b0; hap_act = 1'b1;
      cyc(TMO - 6);
      check("R8 no abort before timeout", abort_cnt, 0);
      cyc(12);
      check("R8 abort after timeout", abort_cnt, 1);
      cyc(3 * TMO);
      check("R11 no second abort without edge", abort_cnt, 1);
      ext_pulse(3, 3);
      cyc(TMO + 4);
      check("R11 new edge re-arms abort", abort_cnt, 2);
      hap_act = 1'b0; cyc(2);
   endtask

   task automatic t_wdog_edges();
      set_cfg(4'b0001);
      hap_act = 1'b1;
      for (int i = 0; i < 12; i++) ext_pulse(TMO / 4, TMO / 4);
      check("R10 regular edges never abort", abort_cnt, 0);
      hap_act = 1'b0; cyc(2);
   endtask

   task automatic t_wdog_disarmed();
      set_cfg(4'b0000);
      hap_act = 1'b1; cyc(3 * TMO);
      check("R9 no abort with internal source", abort_cnt, 0);
      hap_act = 1'b0; cfg = 4'b0001; cyc(3 * TMO);
      check("R9 no abort when haptic idle", abort_cnt, 0);
      hap_act = 1'b1; cyc(TMO - 6);
      check("R9 window restarts on re-arm", abort_cnt, 0);
      cyc(12);
      check("R9 abort after re-arm timeout", abort_cnt, 1);
      hap_act = 1'b0; cyc(2);
   endtask

   task automatic t_wdog_cfg();
      set_cfg(4'b0001);
      hap_act = 1'b1;
      for (int i = 0; i < 6; i++) begin
         cyc(TMO / 2);
         cfg = (cfg == 4'b0001) ? 4'b0011 : 4'b0001;
      end
      cyc(TMO / 2);
      check("R12 config change restarts window", abort_cnt, 0);
      hap_act = 1'b0; cyc(2);
   endtask

   initial begin
      t_reset();
      t_int_latency();
      t_div(1, 10);
      t_div(3, 20);
      t_div(5, 64);
      t_div(7, 256);
      t_clear_div();
      t_ext_src();
      t_ext_ignored();
      t_wdog_fire();
      t_wdog_edges();
      t_wdog_disarmed();
      t_wdog_cfg();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule